// File: doc/BRIEF.md
# Addressable Channel Enable Latch

This block holds the on/off state of a bank of switch channels, eight by default. A binary address picks one channel. A shared active-low data line gives that channel its new state. Two control inputs set what happens to the whole bank on each clock edge:

- A write-disable input freezes the bank.
- A force-off input clears channels.

What force-off clears depends on whether writing is enabled.

All control inputs are sampled on the rising clock edge. The channel-enable vector comes straight from flops, so no input reaches the outputs without a register in between. A system controller drives the block one cycle at a time. To program channels one by one, it steps the address with writing enabled. To hold the pattern while the address bus is busy with other work, it raises write-disable. To clear the bank, it raises force-off.

Top module: `chan_latch8`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every bit of `chan_on` becomes 0 on that edge, whatever the other inputs are.
- R2: With `wr_dis` = 0 and `force_off` = 0, the channel whose index equals `addr` becomes on (bit `addr` of `chan_on` = 1) when `data_n` = 0, and off (bit = 0) when `data_n` = 1, after the edge.
- R3: With `wr_dis` = 0 and `force_off` = 0, every channel other than the addressed one keeps its previous value across the edge.
- R4: With `wr_dis` = 1 and `force_off` = 0, all channels keep their previous value across the edge, for any `data_n` and any `addr`, including an address change.
- R5: With `wr_dis` = 0 and `force_off` = 1, the addressed channel takes the inverse of `data_n`, and every other channel becomes off, after the edge.
- R6: With `wr_dis` = 1 and `force_off` = 1, all channels, including the addressed one, become off after the edge.
- R7: `chan_on` changes only at a rising clock edge. An input change between edges does not show on `chan_on` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Index of the channel being written |
| data_n | input | 1 | New state for the addressed channel, 0 = on, 1 = off |
| wr_dis | input | 1 | Write disable, 1 = freeze the addressed channel |
| force_off | input | 1 | Clears the unaddressed channels, or all channels when combined with `wr_dis` |
| chan_on | output | 8 | Channel enables, bit n = 1 when channel n is on |

## Verification
The only state in this block is the channel vector, and every bit of it is visible at `chan_on`. A bad decode, a polarity slip or a wrong mode branch therefore shows on the port one edge after the offending input. A fault in a held channel can stay hidden until the next edge that should leave that channel untouched. For that reason the stimulus writes several channels and then runs hold and partial-clear cycles with the address moving, so a stray update shows up as a changed bit within one cycle.

// File: rtl/chan_latch8.sv
module chan_latch8 #(
  parameter  int NCH = 8,
  localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           data_n,
  input  logic           wr_dis,
  input  logic           force_off,
  output logic [NCH-1:0] chan_on
);

  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic [NCH-1:0] sel;
  logic [NCH-1:0] nxt;
  logic [NCH-1:0] q;

  assign sel = ONE << addr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      if (force_off)
        nxt[i] = sel[i] & ~wr_dis & ~data_n;
      else if (!wr_dis && sel[i])
        nxt[i] = ~data_n;
      else
        nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign chan_on = q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> chan_on == '0);

  p_write_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && !force_off) |=> chan_on[$past(addr)] == !$past(data_n));

  p_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && !force_off) |=>
      ((chan_on ^ $past(chan_on)) & ~(ONE << $past(addr))) == '0);

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_dis && !force_off) |=> chan_on == $past(chan_on));

  p_set_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && force_off) |=> chan_on[$past(addr)] == !$past(data_n));

  p_set_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && force_off) |=> (chan_on & ~(ONE << $past(addr))) == '0);

  p_all_off_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_dis && force_off) |=> chan_on == '0);

  p_one_change_r3: assert property (@(posedge clk) disable iff (rst)
    !force_off |=> $countones(chan_on ^ $past(chan_on)) <= 1);

endmodule

// File: tb/chan_latch8_bench.sv
module chan_latch8_bench;
  // Requirements covered: R1 R2 R3 R4 R5 R6 R7

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] addr;
  logic       data_n;
  logic       wr_dis;
  logic       force_off;
  logic [7:0] chan_on;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  chan_latch8 u_chan_latch8 (
    .clk(clk), .rst(rst), .addr(addr), .data_n(data_n),
    .wr_dis(wr_dis), .force_off(force_off), .chan_on(chan_on)
  );

  // {req, addr, data_n, wr_dis, force_off, expected chan_on}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2, 3'd3, 1'b0, 1'b0, 1'b0, 8'h08},
    {4'd3, 3'd5, 1'b0, 1'b0, 1'b0, 8'h28},
    {4'd2, 3'd3, 1'b1, 1'b0, 1'b0, 8'h20},
    {4'd4, 3'd7, 1'b0, 1'b1, 1'b0, 8'h20},
    {4'd4, 3'd0, 1'b0, 1'b1, 1'b0, 8'h20},
    {4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 8'h21},
    {4'd3, 3'd1, 1'b0, 1'b0, 1'b0, 8'h23},
    {4'd5, 3'd6, 1'b0, 1'b0, 1'b1, 8'h40},
    {4'd5, 3'd2, 1'b1, 1'b0, 1'b1, 8'h00},
    {4'd2, 3'd2, 1'b0, 1'b0, 1'b0, 8'h04},
    {4'd3, 3'd4, 1'b0, 1'b0, 1'b0, 8'h14},
    {4'd6, 3'd4, 1'b0, 1'b1, 1'b1, 8'h00},
    {4'd2, 3'd7, 1'b0, 1'b0, 1'b0, 8'h80},
    {4'd4, 3'd7, 1'b1, 1'b1, 1'b0, 8'h80}
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: chan_on=%h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic d, input logic wd, input logic s);
    addr = a; data_n = d; wr_dis = wd; force_off = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] model(input logic [7:0] cur, input logic [2:0] a,
                                       input logic d, input logic wd, input logic s);
    logic [7:0] r;
    r = cur;
    if (!wd && !s) r[a] = ~d;
    else if (!wd && s) begin r = '0; r[a] = ~d; end
    else if (wd && s) r = '0;
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ref_q;
    rst = 1'b1; addr = '0; data_n = 1'b0; wr_dis = 1'b0; force_off = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1, chan_on, 8'h00);  // R1 reset, even with a write pending
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13:11], VEC[i][10], VEC[i][9], VEC[i][8]);
      check(int'(VEC[i][17:14]), chan_on, VEC[i][7:0]);
    end

    // R7: a write applied between edges must not show before the next edge
    addr = 3'd1; data_n = 1'b0; wr_dis = 1'b0; force_off = 1'b0;
    #5;
    check(7, chan_on, 8'h80);
    @(posedge clk); @(negedge clk);
    check(7, chan_on, 8'h82);

    // R1: reset from a non-zero state
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1, chan_on, 8'h00);
    rst = 1'b0;

    // Reference-model sweep: all modes, both data values, every address
    ref_q = 8'h00;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int a = 0; a < 8; a++) begin
          logic wd, s;
          int req;
          wd = m[1];
          s  = m[0];
          req = (!wd && !s) ? 2 : (wd && !s) ? 4 : (!wd && s) ? 5 : 6;
          step(3'(a), d[0], wd, s);
          ref_q = model(ref_q, 3'(a), d[0], wd, s);
          check(req, chan_on, ref_q);
        end
        // refill alternate channels so the next pass starts from a pattern
        for (int a = 0; a < 8; a += 2) begin
          step(3'(a), 1'b0, 1'b0, 1'b0);
          ref_q = model(ref_q, 3'(a), 1'b0, 1'b0, 1'b0);
          check(3, chan_on, ref_q);  // R3 others untouched
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule